// File: doc/BRIEF.md
# Speculative Two-Stage Booth Multiplier

This block multiplies two signed 16-bit operands and returns a 32-bit product over two pipeline stages. The first stage builds radix-4 Booth partial products and reduces them to a sum vector and a carry vector. It then adds the lower and upper halves separately. The carry that crosses the split point is not propagated. It is guessed from the top two bit columns of the lower half. The sum of the two halves is presented as a speculative product one cycle after the operands are accepted.

The second stage computes the real carry out of the lower half and compares it with the guess. When the two differ, the upper half is moved up or down by one and the result is flagged as corrected. A consumer whose next operation depends on the product marks that operation with a dependence flag. Such a consumer reads the speculative product early. The input side pauses for one cycle only when the speculation for a dependent operation turns out wrong. An operation issued in approximate mode passes the speculative product through unchanged and never pauses the input.

Top module: `spec_booth_mul`

## Requirements
- R1: A synchronous active-high reset empties both stages: `spec_valid` and `res_valid` are low in the cycle after reset, and `in_ready` is high.
- R2: An operation accepted on a clock edge (`in_valid` and `in_ready` high) gives `spec_valid` high after that edge and `res_valid` high one edge later. Operations without a stall are accepted one per cycle.
- R3: The low 16 bits of `spec_prod` always equal the low 16 bits of the exact product. The whole `spec_prod` equals the exact product, or differs from it by exactly +65536 or -65536 modulo 2^32.
- R4: For a non-approximate operation, `res_prod` equals the exact signed product of `in_a` and `in_b`.
- R5: For a non-approximate operation, `res_fixed` is high exactly when `spec_prod` differed from the exact product. When `res_fixed` is low, `res_prod` equals the preceding `spec_prod` bit for bit.
- R6: `in_ready` is low only in a cycle where the operation in stage one was issued with `in_dep` high and `in_approx` low and its `spec_prod` is wrong. A low cycle lasts exactly one cycle. A dependent operation with a correct guess causes no stall, and neither does a wrong guess without dependence.
- R7: For an operation issued with `in_approx` high, `res_prod` equals its `spec_prod`, `res_fixed` is low, and `in_ready` stays high, even if the guess is wrong.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Operand pair will be taken on this edge |
| in_a | input | 16 | Multiplicand, two's complement |
| in_b | input | 16 | Multiplier, two's complement |
| in_dep | input | 1 | The next operation depends on this product |
| in_approx | input | 1 | Forward the speculative product without correction |
| spec_valid | output | 1 | Speculative product is present |
| spec_prod | output | 32 | Speculative product from stage one |
| res_valid | output | 1 | Final product is present |
| res_prod | output | 32 | Final product from stage two |
| res_fixed | output | 1 | Stage two changed the upper half of the product |

## Verification
Two events can coincide at stage one: a wrong carry guess and a dependence mark. Only their overlap is allowed to pause the input. The bench issues several hundred random operand pairs back to back, with the dependence and approximate flags chosen at random. It finds out whether each guess was wrong by comparing the observed speculative product with a product it computes itself. From this it knows in which cycle `in_ready` must drop. It also requires that all three cases occurred: an overlap, a dependent operation with a correct guess, and a wrong guess without dependence.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    localparam int MUL_W     = 16;
    localparam int SPLIT_POS = 16;
    localparam int GUESS_W   = 2;

    typedef enum logic [2:0] {
        BD_ZERO,
        BD_POS1,
        BD_POS2,
        BD_NEG1,
        BD_NEG2
    } booth_dig_e;

    function automatic booth_dig_e booth_decode(input logic [2:0] tri_bits);
        booth_dig_e d;
        case (tri_bits)
            3'b001, 3'b010: d = BD_POS1;
            3'b011:         d = BD_POS2;
            3'b100:         d = BD_NEG2;
            3'b101, 3'b110: d = BD_NEG1;
            default:        d = BD_ZERO;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sbm_booth_pp.sv
module sbm_booth_pp #(
    parameter int OP_W = 16,
    localparam int PROD_W = 2 * OP_W,
    localparam int NPP    = OP_W / 2
) (
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic [PROD_W-1:0] pp [NPP]
);
    import sbm_pkg::*;

    logic [OP_W:0]       b_ext;
    logic [PROD_W-1:0]   a_ext;

    assign b_ext = {b, 1'b0};
    assign a_ext = {{(PROD_W-OP_W){a[OP_W-1]}}, a};

    for (genvar i = 0; i < NPP; i++) begin : g_row
        booth_dig_e        dig;
        logic [PROD_W-1:0] mag;

        assign dig = booth_decode(b_ext[2*i+2 -: 3]);

        always_comb begin
            case (dig)
                BD_POS1: mag = a_ext;
                BD_POS2: mag = a_ext << 1;
                BD_NEG1: mag = -a_ext;
                BD_NEG2: mag = -(a_ext << 1);
                default: mag = '0;
            endcase
        end

        assign pp[i] = mag << (2 * i);
    end

endmodule

// File: rtl/sbm_csa_chain.sv
module sbm_csa_chain #(
    parameter int W   = 32,
    parameter int NIN = 8,
    localparam int STEPS = NIN - 2
) (
    input  logic [W-1:0] rows [NIN],
    output logic [W-1:0] sum_v,
    output logic [W-1:0] car_v
);
    logic [W-1:0] s_q [STEPS+1];
    logic [W-1:0] c_q [STEPS+1];

    assign s_q[0] = rows[0];
    assign c_q[0] = rows[1];

    for (genvar k = 0; k < STEPS; k++) begin : g_csa
        logic [W-1:0] x, y, z;
        assign x = s_q[k];
        assign y = c_q[k];
        assign z = rows[k+2];
        assign s_q[k+1] = x ^ y ^ z;
        assign c_q[k+1] = ((x & y) | (x & z) | (y & z)) << 1;
    end

    assign sum_v = s_q[STEPS];
    assign car_v = c_q[STEPS];

endmodule

// File: rtl/sbm_split_add.sv
module sbm_split_add #(
    parameter int W     = 32,
    parameter int SPLIT = 16,
    parameter int EST_W = 2,
    localparam int HI_W = W - SPLIT
) (
    input  logic [W-1:0]     sum_v,
    input  logic [W-1:0]     car_v,
    output logic [W-1:0]     guess_prod,
    output logic             carry_guess,
    output logic [SPLIT-1:0] lo_sum_v,
    output logic [SPLIT-1:0] lo_car_v
);
    logic [EST_W:0]   est_add;
    logic [SPLIT-1:0] lo_res;
    logic [HI_W-1:0]  hi_res;

    assign lo_sum_v = sum_v[SPLIT-1:0];
    assign lo_car_v = car_v[SPLIT-1:0];

    assign est_add = {1'b0, sum_v[SPLIT-1 -: EST_W]} + {1'b0, car_v[SPLIT-1 -: EST_W]};
    assign carry_guess = est_add[EST_W];

    assign lo_res = sum_v[SPLIT-1:0] + car_v[SPLIT-1:0];
    assign hi_res = sum_v[W-1:SPLIT] + car_v[W-1:SPLIT] + {{(HI_W-1){1'b0}}, carry_guess};

    assign guess_prod = {hi_res, lo_res};

endmodule

// File: rtl/sbm_fixup.sv
module sbm_fixup #(
    parameter int SPLIT = 16,
    parameter int HI_W  = 16
) (
    input  logic [SPLIT-1:0] lo_sum_v,
    input  logic [SPLIT-1:0] lo_car_v,
    input  logic             carry_guess,
    input  logic [HI_W-1:0]  guess_hi,
    output logic             miss,
    output logic [HI_W-1:0]  fixed_hi
);
    logic [SPLIT:0] full_lo;
    logic           true_carry;

    assign full_lo    = {1'b0, lo_sum_v} + {1'b0, lo_car_v};
    assign true_carry = full_lo[SPLIT];
    assign miss       = true_carry ^ carry_guess;

    always_comb begin
        if (!miss)
            fixed_hi = guess_hi;
        else if (true_carry)
            fixed_hi = guess_hi + 1'b1;
        else
            fixed_hi = guess_hi - 1'b1;
    end

endmodule

// File: rtl/spec_booth_mul.sv
module spec_booth_mul #(
    parameter int OP_W  = sbm_pkg::MUL_W,
    parameter int SPLIT = sbm_pkg::SPLIT_POS,
    parameter int EST_W = sbm_pkg::GUESS_W,
    localparam int PROD_W = 2 * OP_W,
    localparam int NPP    = OP_W / 2,
    localparam int HI_W   = PROD_W - SPLIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_a,
    input  logic [OP_W-1:0]   in_b,
    input  logic              in_dep,
    input  logic              in_approx,
    output logic              spec_valid,
    output logic [PROD_W-1:0] spec_prod,
    output logic              res_valid,
    output logic [PROD_W-1:0] res_prod,
    output logic              res_fixed
);
    typedef struct packed {
        logic              dep;
        logic              approx;
        logic              guess_c;
        logic [SPLIT-1:0]  lo_s;
        logic [SPLIT-1:0]  lo_c;
        logic [PROD_W-1:0] prod;
    } stage1_t;

    logic [PROD_W-1:0] pp [NPP];
    logic [PROD_W-1:0] red_s, red_c;
    logic [PROD_W-1:0] guess_prod;
    logic              guess_c;
    logic [SPLIT-1:0]  lo_s, lo_c;

    stage1_t           s1_q;
    logic              s1_v;
    logic              miss;
    logic [HI_W-1:0]   fixed_hi;
    logic              accept;
    logic              use_fix;

    sbm_booth_pp #(.OP_W(OP_W)) u_pp (
        .a  (in_a),
        .b  (in_b),
        .pp (pp)
    );

    sbm_csa_chain #(.W(PROD_W), .NIN(NPP)) u_csa (
        .rows  (pp),
        .sum_v (red_s),
        .car_v (red_c)
    );

    sbm_split_add #(.W(PROD_W), .SPLIT(SPLIT), .EST_W(EST_W)) u_add (
        .sum_v       (red_s),
        .car_v       (red_c),
        .guess_prod  (guess_prod),
        .carry_guess (guess_c),
        .lo_sum_v    (lo_s),
        .lo_car_v    (lo_c)
    );

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            s1_q <= '0;
        end else begin
            s1_v <= accept;
            if (accept) begin
                s1_q.dep     <= in_dep;
                s1_q.approx  <= in_approx;
                s1_q.guess_c <= guess_c;
                s1_q.lo_s    <= lo_s;
                s1_q.lo_c    <= lo_c;
                s1_q.prod    <= guess_prod;
            end
        end
    end

    sbm_fixup #(.SPLIT(SPLIT), .HI_W(HI_W)) u_fix (
        .lo_sum_v    (s1_q.lo_s),
        .lo_car_v    (s1_q.lo_c),
        .carry_guess (s1_q.guess_c),
        .guess_hi    (s1_q.prod[PROD_W-1:SPLIT]),
        .miss        (miss),
        .fixed_hi    (fixed_hi)
    );

    assign use_fix  = miss && !s1_q.approx;
    assign in_ready = !(s1_v && s1_q.dep && use_fix);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_prod  <= '0;
            res_fixed <= 1'b0;
        end else begin
            res_valid <= s1_v;
            res_fixed <= s1_v && use_fix;
            if (s1_v)
                res_prod <= use_fix ? {fixed_hi, s1_q.prod[SPLIT-1:0]} : s1_q.prod;
        end
    end

    assign spec_valid = s1_v;
    assign spec_prod  = s1_q.prod;

endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
    parameter int PROD_W = 32,
    parameter int SPLIT  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              spec_valid,
    input logic [PROD_W-1:0] spec_prod,
    input logic              res_valid,
    input logic [PROD_W-1:0] res_prod,
    input logic              res_fixed
);
    a_r1_reset_empties: assert property (@(posedge clk)
        rst |=> (!spec_valid && !res_valid && !res_fixed));

    a_r2_spec_after_accept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> spec_valid);

    a_r2_no_spec_without_accept: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> !spec_valid);

    a_r2_res_after_spec: assert property (@(posedge clk) disable iff (rst)
        spec_valid |=> res_valid);

    a_r3_lower_half_kept: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_prod[SPLIT-1:0] == $past(spec_prod[SPLIT-1:0])));

    a_r5_clean_equals_spec: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_fixed) |-> (res_prod == $past(spec_prod)));

    a_r5_fixed_has_valid: assert property (@(posedge clk) disable iff (rst)
        res_fixed |-> res_valid);

    a_r6_stall_single: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> in_ready);

    a_r6_stall_needs_spec: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> spec_valid);

    a_r6_stall_gives_fix: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> res_fixed);

endmodule

bind spec_booth_mul sbm_checker #(.PROD_W(PROD_W), .SPLIT(SPLIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .spec_valid (spec_valid),
    .spec_prod  (spec_prod),
    .res_valid  (res_valid),
    .res_prod   (res_prod),
    .res_fixed  (res_fixed)
);

// File: tb/spec_booth_mul_bench.sv
module spec_booth_mul_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_a, in_b;
    logic        in_dep, in_approx;
    logic        spec_valid;
    logic [31:0] spec_prod;
    logic        res_valid;
    logic [31:0] res_prod;
    logic        res_fixed;

    typedef struct {
        logic [31:0] exact;
        logic        dep;
        logic        approx;
    } op_t;

    typedef struct {
        logic [31:0] exact;
        logic [31:0] spec;
        logic        approx;
        logic        wrong;
    } res_t;

    op_t  spec_q[$];
    res_t res_q[$];

    int total = 0;
    int bad   = 0;
    int n_overlap = 0, n_dep_ok = 0, n_wrong_free = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    spec_booth_mul u_spec_booth_mul (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_a       (in_a),
        .in_b       (in_b),
        .in_dep     (in_dep),
        .in_approx  (in_approx),
        .spec_valid (spec_valid),
        .spec_prod  (spec_prod),
        .res_valid  (res_valid),
        .res_prod   (res_prod),
        .res_fixed  (res_fixed)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send(input logic [15:0] a, input logic [15:0] b, input bit dep, input bit apx);
        op_t o;
        in_valid  = 1'b1;
        in_a      = a;
        in_b      = b;
        in_dep    = dep;
        in_approx = apx;
        while (!in_ready) @(negedge clk);
        o.exact  = 32'($signed(a) * $signed(b));
        o.dep    = dep;
        o.approx = apx;
        spec_q.push_back(o);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: final results first, then speculative ones of this cycle.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (res_valid) begin
                if (res_q.size() == 0) begin
                    check(1'b0, "R2 unexpected res_valid", 32'd1, 32'd0);
                end else begin
                    res_t r;
                    r = res_q.pop_front();
                    if (r.approx) begin
                        check(res_prod == r.spec, "R7 approx result", res_prod, r.spec);
                        check(res_fixed == 1'b0, "R7 approx fixed flag", 32'(res_fixed), 32'd0);
                    end else begin
                        check(res_prod == r.exact, "R4 final product", res_prod, r.exact);
                        check(res_fixed == r.wrong, "R5 fixed flag", 32'(res_fixed), 32'(r.wrong));
                        if (!r.wrong)
                            check(res_prod == r.spec, "R5 clean equals spec", res_prod, r.spec);
                    end
                end
            end
            if (spec_valid) begin
                if (spec_q.size() == 0) begin
                    check(1'b0, "R2 unexpected spec_valid", 32'd1, 32'd0);
                end else begin
                    op_t  o;
                    res_t r;
                    logic [31:0] diff;
                    bit   stall_exp;
                    o = spec_q.pop_front();
                    diff = spec_prod - o.exact;
                    check(spec_prod[15:0] == o.exact[15:0], "R3 low half exact", spec_prod, o.exact);
                    check(diff == 32'h0 || diff == 32'h0001_0000 || diff == 32'hFFFF_0000,
                          "R3 guess within one upper step", spec_prod, o.exact);
                    r.exact  = o.exact;
                    r.spec   = spec_prod;
                    r.approx = o.approx;
                    r.wrong  = (diff != 32'h0);
                    stall_exp = o.dep && r.wrong && !o.approx;
                    if (o.approx)
                        check(in_ready == 1'b1, "R7 approx never stalls", 32'(in_ready), 32'd1);
                    else
                        check(in_ready == !stall_exp, "R6 stall rule", 32'(in_ready), 32'(!stall_exp));
                    if (stall_exp) n_overlap++;
                    if (o.dep && !r.wrong && !o.approx) n_dep_ok++;
                    if (!o.dep && r.wrong && !o.approx) n_wrong_free++;
                    res_q.push_back(r);
                end
            end else begin
                check(in_ready == 1'b1, "R6 no stall when stage one empty", 32'(in_ready), 32'd1);
            end
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_a = '0;
        in_b = '0;
        in_dep = 1'b0;
        in_approx = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(spec_valid == 1'b0, "R1 spec_valid in reset", 32'(spec_valid), 32'd0);
        check(res_valid == 1'b0, "R1 res_valid in reset", 32'(res_valid), 32'd0);
        check(in_ready == 1'b1, "R1 ready in reset", 32'(in_ready), 32'd1);
        rst = 1'b0;
        @(negedge clk);

        // R4 corner operands
        send(16'h7FFF, 16'h7FFF, 1'b1, 1'b0);
        send(16'h8000, 16'h8000, 1'b1, 1'b0);
        send(16'h8000, 16'h7FFF, 1'b0, 1'b0);
        send(16'h0000, 16'hBEEF, 1'b1, 1'b0);
        send(16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
        send(16'hFFFF, 16'h0001, 1'b1, 1'b0);
        repeat (4) @(negedge clk);

        // random stream with dependence and approximate flags (R6, R7)
        for (int i = 0; i < 600; i++) begin
            logic [15:0] ra, rb;
            bit rd, rx;
            ra = 16'($urandom);
            rb = 16'($urandom);
            rd = ($urandom_range(0, 1) == 1);
            rx = ($urandom_range(0, 4) == 0);
            send(ra, rb, rd, rx);
            if ($urandom_range(0, 9) == 0) @(negedge clk);
        end

        // mid-stream reset clears the pipeline (R1)
        send(16'h1234, 16'h5678, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        spec_q.delete();
        res_q.delete();
        check(spec_valid == 1'b0, "R1 spec cleared by reset", 32'(spec_valid), 32'd0);
        check(res_valid == 1'b0, "R1 res cleared by reset", 32'(res_valid), 32'd0);
        send(16'h0003, 16'hFFFB, 1'b1, 1'b0);
        repeat (5) @(negedge clk);

        check(spec_q.size() == 0 && res_q.size() == 0, "R2 every operation completed",
              32'(spec_q.size() + res_q.size()), 32'd0);
        check(n_overlap > 0, "R6 overlap case seen", 32'(n_overlap), 32'd1);
        check(n_dep_ok > 0, "R6 dependent correct guess seen", 32'(n_dep_ok), 32'd1);
        check(n_wrong_free > 0, "R6 wrong guess without dependence seen", 32'(n_wrong_free), 32'd1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            check(1'b0, "R2 watchdog expired", 32'd1, 32'd0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule